// File: doc/BRIEF.md
# Serial Flash Instruction Fetch Cache

This block lets a small processor run its program straight out of an external serial flash. Fetched code sits in a direct-mapped cache built from one on-chip RAM of 2^(IDX_W+OFF_W) bytes, split into 16-byte lines. On a miss, the block fills the whole line from the flash using the fast-read command: opcode 0x0B, a 24-bit address and one dummy byte, after which data bytes stream out.

When a fill ends, the block does not close the flash transaction. It leaves chip select low, parks SCK low and drives HOLD_n low, so the flash freezes its output at the next bit. If the next miss is for the line that directly follows, the block releases HOLD_n and clocks the data on with no new command. Any other miss closes the transaction and opens a new one. That restart costs the 40 command bits again.

The processor side is a held request. The processor keeps `req_valid` and `req_addr` steady until `rsp_ready` pulses. SCK runs at half the core clock in SPI mode 0.

Top module: `spi_code_fetch`

## Requirements
- R1: After reset, spi_cs_n and spi_hold_n are high, spi_sck and rsp_ready are low, and every cache line is invalid, so the first request always reaches the flash.
- R2: A miss that cannot continue the open stream sends, MSB first on spi_mosi with bits sampled on rising SCK, the opcode 0x0B, then the 24-bit address of the requested line with its low four bits zero, then eight dummy bits.
- R3: On a miss, rsp_ready pulses when the requested byte arrives. rsp_data then holds the flash byte at req_addr, and bytes are assembled MSB first from spi_miso. The rest of the line is still filled.
- R4: A request to a valid line with a matching tag gets rsp_ready and the cached byte on the clock after it is first seen, with no SCK, chip-select or hold activity.
- R5: Once a line fill completes, spi_cs_n stays low and spi_sck stays low, and spi_hold_n goes low until the next miss.
- R6: A miss whose line address equals the line after the last one filled releases spi_hold_n and resumes the stream without a new command. The byte at offset k is returned 16·(k+1) clocks after the request.
- R7: Any other miss raises spi_cs_n for at least one full SCK period (two clocks) and then restarts the command. The byte at offset k is returned 98+16·k clocks after the request.
- R8: spi_hold_n changes only while spi_sck is low and was low in the previous clock.
- R9: spi_sck is high only while spi_cs_n is low and spi_hold_n is high.
- R10: rsp_ready is a single-clock pulse and appears only while a request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request, held until rsp_ready |
| req_addr | input | 24 | Byte address in flash |
| rsp_ready | output | 1 | One-clock pulse: rsp_data is valid |
| rsp_data | output | 8 | Fetched byte |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Command and address to flash |
| spi_miso | input | 1 | Data from flash |
| spi_hold_n | output | 1 | Pauses the flash while low |

## Verification
A stale tag or valid bit shows up at once as the wrong byte, or as a one-clock answer where a flash access was due. A corrupt stream-address register shows up at the next miss: a command appears where none should, or the resumed bytes come from the wrong place. Bit-count errors or a badly timed hold shift every later byte by a bit, so the first data check after the fault fails. Exact latencies for the hit, continue and restart paths expose any extra or missing state in the sequencer within a single request.

// File: rtl/spi_code_fetch.sv
module spi_code_fetch #(
  parameter int          IDX_W   = 6,
  parameter int          OFF_W   = 4,
  parameter int          GAP_CYC = 2,
  parameter logic [7:0]  RD_OP   = 8'h0B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [23:0] req_addr,
  output logic        rsp_ready,
  output logic [7:0]  rsp_data,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_hold_n
);
  localparam int LN_W     = 24 - OFF_W;
  localparam int TAG_W    = LN_W - IDX_W;
  localparam int LINES    = 1 << IDX_W;
  localparam int BYTES    = 1 << (IDX_W + OFF_W);
  localparam int CMD_BITS = 40;
  localparam int BIT_W    = OFF_W + 3;
  localparam int CNT_W    = (BIT_W > 6) ? BIT_W : 6;
  localparam int G_W      = $clog2(GAP_CYC) + 1;

  typedef enum logic [2:0] {ST_IDLE, ST_GAP, ST_CMD, ST_DATA, ST_PAUSE} st_t;

  st_t                 st;
  logic [7:0]          mem  [BYTES];
  logic [TAG_W-1:0]    tags [LINES];
  logic [LINES-1:0]    valid;
  logic [LN_W-1:0]     nxt;
  logic [CMD_BITS-1:0] sr;
  logic [CNT_W-1:0]    cnt;
  logic [6:0]          inb;
  logic                line_end;
  logic                pend;
  logic [OFF_W-1:0]    pend_off;
  logic [G_W-1:0]      gcnt;

  wire [LN_W-1:0]   rq_line = req_addr[23:OFF_W];
  wire [IDX_W-1:0]  rq_idx  = rq_line[IDX_W-1:0];
  wire [TAG_W-1:0]  rq_tag  = rq_line[LN_W-1:IDX_W];
  wire [OFF_W-1:0]  rq_off  = req_addr[OFF_W-1:0];
  wire              hit     = valid[rq_idx] && (tags[rq_idx] == rq_tag);
  wire              look    = req_valid && !rsp_ready && (st == ST_IDLE || st == ST_PAUSE);
  wire [IDX_W-1:0]  fill_idx = nxt[IDX_W-1:0];
  wire [7:0]        byte_in = {inb, spi_miso};
  wire              d_rise  = (st == ST_DATA) && !spi_sck;
  wire              byte_dn = d_rise && (cnt[2:0] == 3'd7);
  wire              line_dn = d_rise && (cnt[BIT_W-1:0] == {BIT_W{1'b1}});
  wire              cap     = byte_dn && pend && (cnt[BIT_W-1:3] == pend_off);

  assign spi_mosi = sr[CMD_BITS-1];

  always_ff @(posedge clk) begin
    if (byte_dn) mem[{fill_idx, cnt[BIT_W-1:3]}] <= byte_in;
    if (line_dn) tags[fill_idx] <= nxt[LN_W-1:IDX_W];
    if (look && hit) rsp_data <= mem[req_addr[IDX_W+OFF_W-1:0]];
    else if (cap)    rsp_data <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      spi_sck    <= 1'b0;
      spi_cs_n   <= 1'b1;
      spi_hold_n <= 1'b1;
      rsp_ready  <= 1'b0;
      valid      <= '0;
      nxt        <= '0;
      sr         <= '0;
      cnt        <= '0;
      inb        <= '0;
      line_end   <= 1'b0;
      pend       <= 1'b0;
      pend_off   <= '0;
      gcnt       <= '0;
    end else begin
      rsp_ready <= 1'b0;
      case (st)
        ST_IDLE, ST_PAUSE: begin
          if (st == ST_PAUSE) spi_hold_n <= 1'b0;
          if (look && hit) rsp_ready <= 1'b1;
          if (look && !hit) begin
            pend     <= 1'b1;
            pend_off <= rq_off;
            if (st == ST_PAUSE && rq_line == nxt) begin
              spi_hold_n <= 1'b1;
              st         <= ST_DATA;
            end else begin
              spi_cs_n   <= 1'b1;
              spi_hold_n <= 1'b1;
              nxt        <= rq_line;
              gcnt       <= '0;
              st         <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gcnt == G_W'(GAP_CYC - 1)) begin
            spi_cs_n <= 1'b0;
            sr       <= {RD_OP, nxt, {OFF_W{1'b0}}, 8'h00};
            cnt      <= '0;
            st       <= ST_CMD;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_CMD: begin
          spi_sck <= ~spi_sck;
          if (!spi_sck) begin
            cnt <= cnt + 1'b1;
          end else begin
            sr <= sr << 1;
            if (cnt == CNT_W'(CMD_BITS)) begin
              cnt <= '0;
              st  <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          spi_sck <= ~spi_sck;
          if (!spi_sck) begin
            inb <= byte_in[6:0];
            cnt <= cnt + 1'b1;
            if (cap) begin
              rsp_ready <= 1'b1;
              pend      <= 1'b0;
            end
            if (line_dn) begin
              valid[fill_idx] <= 1'b1;
              line_end        <= 1'b1;
              cnt             <= '0;
            end
          end else if (line_end) begin
            line_end <= 1'b0;
            nxt      <= nxt + 1'b1;
            st       <= ST_PAUSE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_code_fetch_chk.sv
module spi_code_fetch_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic rsp_ready,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_hold_n
);
  // R9
  sck_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> (!spi_cs_n && spi_hold_n));

  // R8
  hold_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_hold_n != $past(spi_hold_n)) |-> (!spi_sck && !$past(spi_sck)));

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  // R10
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> $past(req_valid));

  // R7
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  // R5
  hold_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_hold_n |-> !spi_cs_n);
endmodule

bind spi_code_fetch spi_code_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_ready(rsp_ready),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_hold_n(spi_hold_n)
);

// File: tb/spi_code_fetch_bench.sv
module spi_code_fetch_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        rsp_ready;
  logic [7:0]  rsp_data;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_hold_n;
  logic        spi_miso = 1'b0;

  int nchk = 0, nerr = 0;

  spi_code_fetch u_spi_code_fetch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_hold_n(spi_hold_n)
  );

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    logic [23:0] m;
    m = a * 24'd37;
    return m[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic chk(input string rq, input bit ok, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // behavioural serial flash, mode 0, fast read with one dummy byte
  int          ncmd = 0, fbit = 0, fl_cmds = 0;
  logic [31:0] inreg = '0;
  logic [7:0]  fl_op = '0;
  logic [23:0] fl_addr = '0;

  always @(negedge spi_cs_n) begin
    ncmd = 0;
    fbit = 0;
  end

  always @(posedge spi_sck) begin
    if (!spi_cs_n && spi_hold_n && ncmd < 40) begin
      inreg = {inreg[30:0], spi_mosi};
      ncmd++;
      if (ncmd == 32) begin
        fl_cmds++;
        fl_op   = inreg[31:24];
        fl_addr = inreg[23:0];
      end
    end
  end

  always @(negedge spi_sck) begin
    logic [7:0] b;
    if (!spi_cs_n && spi_hold_n && ncmd == 40) begin
      b = fbyte(fl_addr + 24'(fbit / 8));
      spi_miso = b[7 - (fbit % 8)];
      fbit++;
    end
  end

  // per-clock pin monitors
  logic p_hold = 1'b1, p_sck = 1'b0, p_cs = 1'b1;
  int   cs_hi = 0, sck_bad = 0, hold_bad = 0, gap_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_sck && (spi_cs_n || !spi_hold_n)) sck_bad++;
      if (spi_hold_n != p_hold && (spi_sck || p_sck)) hold_bad++;
      if (spi_cs_n) cs_hi++;
      else begin
        if (p_cs && cs_hi < 2) gap_bad++;
        cs_hi = 0;
      end
      p_hold = spi_hold_n;
      p_sck  = spi_sck;
      p_cs   = spi_cs_n;
    end
  end

  // reference model of cache contents and open stream
  bit mv [64];
  int mt [64];
  bit sopen = 1'b0;
  int snext = 0;
  int last_line = 16;

  task automatic do_req(input logic [23:0] a);
    int line, idx, tg, off, kind, lat, expl, c0;
    line = int'(a >> 4);
    idx  = line % 64;
    tg   = line / 64;
    off  = int'(a[3:0]);
    if (mv[idx] && mt[idx] == tg) kind = 0;
    else if (sopen && line == snext) kind = 1;
    else kind = 2;
    @(negedge clk);
    if (sopen) while (spi_hold_n !== 1'b0) @(negedge clk);
    c0 = fl_cmds;
    req_valid = 1'b1;
    req_addr  = a;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (rsp_ready !== 1'b1 && lat < 3000);
    req_valid = 1'b0;
    expl = (kind == 0) ? 1 : (kind == 1) ? 16 * (off + 1) : 98 + 16 * off;
    case (kind)
      0: begin
        chk("R4 hit latency", lat == expl, lat, expl);
        chk("R4 no flash command on hit", fl_cmds == c0, fl_cmds - c0, 0);
        chk("R4 stream stays paused", spi_hold_n == 1'b0 && spi_cs_n == 1'b0, spi_hold_n, 0);
      end
      1: begin
        chk("R6 continue latency", lat == expl, lat, expl);
        chk("R6 no new command", fl_cmds == c0, fl_cmds - c0, 0);
      end
      default: begin
        chk("R7 restart latency", lat == expl, lat, expl);
        chk("R2 one command", fl_cmds == c0 + 1, fl_cmds - c0, 1);
        chk("R2 opcode", fl_op == 8'h0B, fl_op, 8'h0B);
        chk("R2 line address", fl_addr == 24'(line << 4), fl_addr, line << 4);
      end
    endcase
    chk("R3 data byte", rsp_data == fbyte(a), rsp_data, fbyte(a));
    @(negedge clk);
    chk("R10 single pulse", rsp_ready == 1'b0, rsp_ready, 0);
    if (kind != 0) begin
      mv[idx] = 1'b1;
      mt[idx] = tg;
      sopen   = 1'b1;
      snext   = (line + 1) % (1 << 20);
    end
    last_line = line;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] r;
    int ln;
    logic [23:0] a;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cs_n high", spi_cs_n == 1'b1, spi_cs_n, 1);
    chk("R1 hold_n high", spi_hold_n == 1'b1, spi_hold_n, 1);
    chk("R1 sck low", spi_sck == 1'b0, spi_sck, 0);
    chk("R1 ready low", rsp_ready == 1'b0, rsp_ready, 0);

    do_req(24'h000123);
    chk("R1 empty cache reaches flash", fl_cmds == 1, fl_cmds, 1);
    repeat (300) @(negedge clk);
    chk("R5 cs held low", spi_cs_n == 1'b0, spi_cs_n, 0);
    chk("R5 hold asserted", spi_hold_n == 1'b0, spi_hold_n, 0);
    chk("R5 sck parked low", spi_sck == 1'b0, spi_sck, 0);
    chk("R5 no extra command", fl_cmds == 1, fl_cmds, 1);

    do_req(24'h000125);
    do_req(24'h000130);
    do_req(24'h00013F);
    do_req(24'h000147);
    do_req(24'h0A5500);
    do_req(24'h000120);
    do_req(24'h000520);
    do_req(24'h000121);
    do_req(24'h000130);
    do_req(24'h00014C);
    do_req(24'h000150);

    r = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      r = r * 32'd1103515245 + 32'd12345;
      if (r[20:19] == 2'd0) ln = last_line + 1;
      else ln = 16 + int'(r[27:24]) % 10 + (r[28] ? 64 : 0);
      a = 24'(ln << 4) | 24'(r[11:8]);
      do_req(a);
    end

    repeat (10) @(negedge clk);
    chk("R9 sck only while selected and not held", sck_bad == 0, sck_bad, 0);
    chk("R8 hold changes with sck low", hold_bad == 0, hold_bad, 0);
    chk("R7 deselect gap at least one sck period", gap_bad == 0, gap_bad, 0);
    summary();
  end
endmodule